// File: doc/BRIEF.md
# Partial-Width Register File Writer

This block is a general-purpose integer register file of sixteen 64-bit entries with two combinational read ports and one write port. The write port does more than store a word. It takes an operand size, a source size and a write mode, and from these it builds the new register contents. Depending on the mode, the incoming value is placed into the low bytes of the old contents, stored with the upper half cleared, or widened from a smaller source by zero fill or sign fill.

Three modes serve immediates and a fixed operation. One mode widens a 32-bit two's-complement immediate to a full quad word. Another stores a full 64-bit immediate. A third, which takes no operand, widens the low 32 bits of register 0 into all 64 bits of register 0. A combination that does not describe a legal operation raises an error flag in the same cycle and writes nothing.

Each read port returns the low 1, 2, 4 or 8 bytes of the selected register, with zeros above. An execution stage can therefore read operands at the width the instruction names.

Top module: `gpr_merge_file`

## Requirements
- R1: A write takes effect on the rising clock edge at which `wr_en` is high. A read in that same cycle, before the edge, returns the old contents. When `wr_en` is low, no register changes and `wr_err` stays low.
- R2: Sizes are encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A plain write (mode 0) of size 0 or 1 replaces only the low 1 or 2 bytes of the target and keeps every byte above them.
- R3: A plain write of size 2 stores the low 32 bits of `wr_data` and forces bits 63:32 to zero. A plain write of size 3 stores all 64 bits.
- R4: Zero-extend (mode 1) takes the low `wr_src_size` bytes of `wr_data` and fills above them with zeros up to `wr_size`. The result is then stored under the merge rule of R2/R3 for `wr_size`. Legal pairs are source to destination 0→1, 0→2, 1→2, 0→3 and 1→3.
- R5: Sign-extend (mode 2) works like R4, but fills with copies of the source's top bit. Legal pairs are those of R4 plus 2→3.
- R6: An illegal write drives `wr_err` high in the cycle `wr_en` is high and leaves every register unchanged. Illegal writes are: an extension whose source size is not smaller than its destination size, zero-extend 2→3, and modes 6 and 7.
- R7: Mode 3 sign-extends bits 31:0 of `wr_data` to 64 bits. Mode 4 stores all 64 bits of `wr_data`. Both modes are legal only with `wr_size` = 3, and `wr_src_size` is ignored.
- R8: Mode 5 replaces register 0 with its own bits 31:0 sign-extended to 64 bits. `wr_addr`, `wr_data` and both sizes are ignored, and no other register changes.
- R9: Each read port returns the low bytes of the addressed register at its requested size (encoded as in R2), with all higher bits zero.
- R10: A low `rst_n` at a rising edge clears all sixteen registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | 4 | Target register |
| wr_data | input | 64 | Write value or immediate |
| wr_size | input | 2 | Destination operand size |
| wr_src_size | input | 2 | Source size for extension modes |
| wr_mode | input | 3 | 0 plain, 1 zero-ext, 2 sign-ext, 3 imm32, 4 imm64, 5 accumulator widen |
| wr_err | output | 1 | Illegal write combination (combinational) |
| rd_a_addr | input | 4 | Read port A register |
| rd_a_size | input | 2 | Read port A size |
| rd_a_data | output | 64 | Read port A value, zero above size |
| rd_b_addr | input | 4 | Read port B register |
| rd_b_size | input | 2 | Read port B size |
| rd_b_data | output | 64 | Read port B value, zero above size |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that a check of retained bytes is valid only while read port A keeps the same address and size across the write. Each property therefore gates its consequent on `rd_a_addr` and `rd_a_size` being stable. The stimulus drives all inputs at the falling edge and keeps port A pointed at the write target through every write. Illegal combinations are applied on purpose, including modes 6 and 7, so that the error path and the no-change rule are both exercised.

// File: rtl/gprw_pkg.sv
// Shared types for the partial-width register file.
// Assumes a 64-bit register width (the dword case clears bits 63:32).
package gprw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_QWORD = 2'd3
    } opsize_e;

    typedef enum logic [2:0] {
        WM_PLAIN = 3'd0,
        WM_ZEXT  = 3'd1,
        WM_SEXT  = 3'd2,
        WM_IMM32 = 3'd3,
        WM_IMM64 = 3'd4,
        WM_ACCX  = 3'd5
    } wmode_e;

    // Decoded write plan handed from the decoder to the merge datapath.
    typedef struct packed {
        logic    legal;
        logic    from_old;
        logic    sign;
        opsize_e src;
        opsize_e dst;
    } wplan_t;

endpackage

// File: rtl/gprw_ctrl.sv
// Write-plan decoder: turns mode and sizes into source size, destination
// size, fill kind and legality. Purely combinational and holds no state.
module gprw_ctrl
    import gprw_pkg::*;
(
    input  logic [2:0] wr_mode,
    input  logic [1:0] wr_size,
    input  logic [1:0] wr_src_size,
    output wplan_t     plan
);

    opsize_e dsz;
    opsize_e ssz;

    assign dsz = opsize_e'(wr_size);
    assign ssz = opsize_e'(wr_src_size);

    // Decode the mode into a write plan and a legality bit.
    always_comb begin
        plan.legal    = 1'b0;
        plan.from_old = 1'b0;
        plan.sign     = 1'b0;
        plan.src      = dsz;
        plan.dst      = dsz;
        case (wr_mode)
            WM_PLAIN: begin
                plan.legal = 1'b1;
            end
            WM_ZEXT: begin
                plan.src   = ssz;
                plan.legal = (ssz < dsz) && !(ssz == SZ_DWORD);
            end
            WM_SEXT: begin
                plan.src   = ssz;
                plan.sign  = 1'b1;
                plan.legal = (ssz < dsz);
            end
            WM_IMM32: begin
                plan.src   = SZ_DWORD;
                plan.dst   = SZ_QWORD;
                plan.sign  = 1'b1;
                plan.legal = (dsz == SZ_QWORD);
            end
            WM_IMM64: begin
                plan.src   = SZ_QWORD;
                plan.dst   = SZ_QWORD;
                plan.legal = (dsz == SZ_QWORD);
            end
            WM_ACCX: begin
                plan.src      = SZ_DWORD;
                plan.dst      = SZ_QWORD;
                plan.sign     = 1'b1;
                plan.from_old = 1'b1;
                plan.legal    = 1'b1;
            end
            default: begin
                plan.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gprw_merge.sv
// Byte-lane merge datapath: widens the source to the destination size by
// zero or sign fill, then combines it with the old register value under
// the size rule (1/2-byte keep upper bytes, 4-byte clears upper, 8 replaces).
// Assumes XLEN is 64.
module gprw_merge
    import gprw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src_val,
    input  wplan_t          plan,
    output logic [XLEN-1:0] merged
);

    localparam int NB = XLEN / 8;
    localparam int CW = $clog2(NB) + 2;

    logic [NB-1:0][7:0] src_b;
    logic [NB-1:0][7:0] old_b;
    logic [NB-1:0][7:0] ext_b;
    logic [NB-1:0][7:0] out_b;
    logic [CW-1:0]      src_nb;
    logic [CW-1:0]      dst_nb;
    logic               fill_bit;
    logic               clear_hi;

    assign src_b    = src_val;
    assign old_b    = old_val;
    assign src_nb   = CW'(1) << plan.src;
    assign dst_nb   = CW'(1) << plan.dst;
    assign clear_hi = (plan.dst == SZ_DWORD) || (plan.dst == SZ_QWORD);

    // Pick the top bit of the source field for sign fill.
    always_comb begin
        case (plan.src)
            SZ_BYTE:  fill_bit = src_val[7];
            SZ_WORD:  fill_bit = src_val[15];
            SZ_DWORD: fill_bit = src_val[31];
            default:  fill_bit = src_val[XLEN-1];
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        // Widen: source lane, else fill byte.
        assign ext_b[i] = (CW'(i) < src_nb) ? src_b[i] : {8{fill_bit & plan.sign}};
        // Merge: new lane, cleared lane or retained lane.
        assign out_b[i] = (CW'(i) < dst_nb) ? ext_b[i] :
                          (clear_hi ? 8'h00 : old_b[i]);
    end

    assign merged = out_b;

endmodule

// File: rtl/gprw_bank.sv
// Register storage with one write port and three combinational read
// ports (two architectural, one feeding the merge with old contents).
// Synchronous active-low reset clears every entry.
module gprw_bank #(
    parameter int NUM_REGS = 16,
    parameter int XLEN     = 64,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr_a,
    input  logic [AW-1:0]   raddr_b,
    input  logic [AW-1:0]   raddr_c,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    output logic [XLEN-1:0] rdata_c
);

    logic [XLEN-1:0] regs [NUM_REGS];

    // Clear on reset, otherwise store the merged value on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs[k] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];

endmodule

// File: rtl/gprw_rdport.sv
// Read-size trimmer: passes the low 1/2/4/8 bytes of a register value
// and zeros the rest. Combinational and holds no state.
module gprw_rdport #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] full,
    input  logic [1:0]      size,
    output logic [XLEN-1:0] trimmed
);

    localparam int NB = XLEN / 8;
    localparam int CW = $clog2(NB) + 2;

    logic [NB-1:0][7:0] in_b;
    logic [NB-1:0][7:0] out_b;
    logic [CW-1:0]      keep_nb;

    assign in_b    = full;
    assign keep_nb = CW'(1) << size;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign out_b[i] = (CW'(i) < keep_nb) ? in_b[i] : 8'h00;
    end

    assign trimmed = out_b;

endmodule

// File: rtl/gpr_merge_file.sv
// Partial-width register file top. Decodes the write plan, merges the
// write value with the target's old contents and stores it. It also flags
// illegal writes combinationally. Reads are combinational and size-trimmed.
// Assumes XLEN = 64. Mode 5 always targets register 0.
module gpr_merge_file
    import gprw_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int XLEN     = 64,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [1:0]      wr_size,
    input  logic [1:0]      wr_src_size,
    input  logic [2:0]      wr_mode,
    output logic            wr_err,
    input  logic [AW-1:0]   rd_a_addr,
    input  logic [1:0]      rd_a_size,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [AW-1:0]   rd_b_addr,
    input  logic [1:0]      rd_b_size,
    output logic [XLEN-1:0] rd_b_data
);

    wplan_t          plan;
    logic [AW-1:0]   tgt_addr;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] src_val;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] raw_a;
    logic [XLEN-1:0] raw_b;
    logic            commit;

    gprw_ctrl u_ctrl (
        .wr_mode     (wr_mode),
        .wr_size     (wr_size),
        .wr_src_size (wr_src_size),
        .plan        (plan)
    );

    assign tgt_addr = plan.from_old ? '0 : wr_addr;
    assign src_val  = plan.from_old ? old_val : wr_data;
    assign commit   = wr_en & plan.legal;
    assign wr_err   = wr_en & ~plan.legal;

    gprw_merge #(.XLEN(XLEN)) u_merge (
        .old_val (old_val),
        .src_val (src_val),
        .plan    (plan),
        .merged  (merged)
    );

    gprw_bank #(.NUM_REGS(NUM_REGS), .XLEN(XLEN), .AW(AW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (commit),
        .waddr   (tgt_addr),
        .wdata   (merged),
        .raddr_a (rd_a_addr),
        .raddr_b (rd_b_addr),
        .raddr_c (tgt_addr),
        .rdata_a (raw_a),
        .rdata_b (raw_b),
        .rdata_c (old_val)
    );

    gprw_rdport #(.XLEN(XLEN)) u_rd_a (
        .full    (raw_a),
        .size    (rd_a_size),
        .trimmed (rd_a_data)
    );

    gprw_rdport #(.XLEN(XLEN)) u_rd_b (
        .full    (raw_b),
        .size    (rd_b_size),
        .trimmed (rd_b_data)
    );

endmodule

// File: rtl/gpr_merge_file_chk.sv
// Checker for the partial-width register file. It watches the ports only
// and relies on read port A to observe register contents across a write.
module gpr_merge_file_chk #(
    parameter int XLEN = 64,
    parameter int AW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [1:0]      wr_size,
    input logic [2:0]      wr_mode,
    input logic            wr_err,
    input logic [AW-1:0]   rd_a_addr,
    input logic [1:0]      rd_a_size,
    input logic [XLEN-1:0] rd_a_data
);

    // R1: no write request leaves a stably-addressed read unchanged
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(rd_a_addr) || !$stable(rd_a_size) || $stable(rd_a_data)));

    // R6: the error flag only accompanies a write request
    p_err_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> wr_en);

    // R6: an illegal write changes nothing
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> (!$stable(rd_a_addr) || !$stable(rd_a_size) || $stable(rd_a_data)));

    // R7: immediate modes need a quad-word destination
    p_imm_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mode == 3'd3 || wr_mode == 3'd4) && wr_size != 2'd3) |-> wr_err);

    // R2: plain byte write keeps bits 63:8 of the target
    p_byte_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_mode == 3'd0 && wr_size == 2'd0 &&
         rd_a_addr == wr_addr && rd_a_size == 2'd3)
        |=> (!$stable(rd_a_addr) || !$stable(rd_a_size) ||
             rd_a_data[XLEN-1:8] == $past(rd_a_data[XLEN-1:8])));

    // R3: plain dword write clears bits 63:32 of the target
    p_dword_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_mode == 3'd0 && wr_size == 2'd2 &&
         rd_a_addr == wr_addr && rd_a_size == 2'd3)
        |=> (!$stable(rd_a_addr) || !$stable(rd_a_size) || rd_a_data[XLEN-1:32] == '0));

    // R9: a byte-size read is zero above bit 7
    p_read_trim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_size == 2'd0) |-> (rd_a_data[XLEN-1:8] == '0));

    // R10: reset leaves every register, and so any read, at zero
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (rd_a_data == '0));

endmodule

bind gpr_merge_file gpr_merge_file_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_mode   (wr_mode),
    .wr_err    (wr_err),
    .rd_a_addr (rd_a_addr),
    .rd_a_size (rd_a_size),
    .rd_a_data (rd_a_data)
);

// File: tb/gpr_merge_file_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them 2 ns after each falling edge.
module gpr_merge_file_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_size = '0;
    logic [1:0]  wr_src_size = '0;
    logic [2:0]  wr_mode = '0;
    logic        wr_err;
    logic [3:0]  rd_a_addr = '0;
    logic [1:0]  rd_a_size = 2'd3;
    logic [63:0] rd_a_data;
    logic [3:0]  rd_b_addr = '0;
    logic [1:0]  rd_b_size = 2'd3;
    logic [63:0] rd_b_data;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] model [16];

    typedef struct {
        int          kind;   // 0 port A, 1 port B, 2 wr_err
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    gpr_merge_file u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size(wr_size), .wr_src_size(wr_src_size),
        .wr_mode(wr_mode), .wr_err(wr_err),
        .rd_a_addr(rd_a_addr), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data)
    );

    function automatic logic [63:0] size_mask(logic [1:0] s);
        case (s)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] widen(logic [63:0] d, logic [1:0] s, bit sgn);
        case (s)
            2'd0:    return sgn ? {{56{d[7]}},  d[7:0]}  : {56'h0, d[7:0]};
            2'd1:    return sgn ? {{48{d[15]}}, d[15:0]} : {48'h0, d[15:0]};
            2'd2:    return sgn ? {{32{d[31]}}, d[31:0]} : {32'h0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] place(logic [63:0] old, logic [63:0] v, logic [1:0] s);
        case (s)
            2'd0:    return {old[63:8], v[7:0]};
            2'd1:    return {old[63:16], v[15:0]};
            2'd2:    return {32'h0, v[31:0]};
            default: return v;
        endcase
    endfunction

    task automatic push(int kind, logic [63:0] exp, string tag);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare every queued expectation against the ports.
    always @(negedge clk) begin
        #2;
        while (sb_q.size() != 0) begin
            sb_item_t    it;
            logic [63:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = rd_a_data;
                1:       act = rd_b_data;
                default: act = {63'h0, wr_err};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    // Driver: apply one write, expect old contents before the edge and the error flag.
    task automatic do_write(logic [3:0] a, logic [1:0] sz, logic [1:0] ssz,
                            logic [2:0] md, logic [63:0] d, string tag);
        bit          legal;
        logic [3:0]  tgt;
        logic [63:0] nv;
        tgt   = (md == 3'd5) ? 4'd0 : a;
        legal = 0;
        nv    = model[tgt];
        case (md)
            3'd0: begin legal = 1; nv = place(model[tgt], d, sz); end
            3'd1: begin
                legal = (ssz < sz) && (ssz != 2'd2);
                nv = place(model[tgt], widen(d, ssz, 0), sz);
            end
            3'd2: begin
                legal = (ssz < sz);
                nv = place(model[tgt], widen(d, ssz, 1), sz);
            end
            3'd3: begin legal = (sz == 2'd3); nv = widen(d, 2'd2, 1); end
            3'd4: begin legal = (sz == 2'd3); nv = d; end
            3'd5: begin legal = 1; nv = widen(model[0], 2'd2, 1); end
            default: legal = 0;
        endcase
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_size = sz; wr_src_size = ssz;
        wr_mode = md; wr_data = d;
        rd_a_addr = tgt; rd_a_size = 2'd3;
        push(0, model[tgt], {tag, " R1 old value before edge"});
        push(2, {63'h0, !legal}, {tag, " error flag"});
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (legal) model[tgt] = nv;
    endtask

    task automatic check_a(logic [3:0] a, logic [1:0] sz, string tag);
        @(negedge clk);
        rd_a_addr = a; rd_a_size = sz;
        push(0, model[a] & size_mask(sz), tag);
    endtask

    task automatic check_b(logic [3:0] a, logic [1:0] sz, string tag);
        @(negedge clk);
        rd_b_addr = a; rd_b_size = sz;
        push(1, model[a] & size_mask(sz), tag);
    endtask

    task automatic expect_val(logic [3:0] a, logic [63:0] v, string tag);
        @(negedge clk);
        rd_a_addr = a; rd_a_size = 2'd3;
        push(0, v, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) model[k] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state
        for (int k = 0; k < 16; k++) check_a(4'(k), 2'd3, "R10 reset clears register");
        @(negedge clk); push(2, 64'h0, "R10 no error after reset");

        // R7: absolute 64-bit immediate
        do_write(4'd0, 2'd3, 2'd0, 3'd4, 64'h0011_2233_4455_6677, "R7 imm64");
        expect_val(4'd0, 64'h0011_2233_4455_6677, "R7 imm64 value");
        // R2: byte and word merges keep upper bytes
        do_write(4'd0, 2'd0, 2'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFAA, "R2 byte");
        expect_val(4'd0, 64'h0011_2233_4455_66AA, "R2 byte keeps upper");
        do_write(4'd0, 2'd1, 2'd0, 3'd0, 64'h1234_0000_0000_BEEF, "R2 word");
        expect_val(4'd0, 64'h0011_2233_4455_BEEF, "R2 word keeps upper");
        // R3: dword clears upper, qword full
        do_write(4'd1, 2'd3, 2'd0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R7 preset r1");
        do_write(4'd1, 2'd2, 2'd0, 3'd0, 64'h1234_5678_CAFE_F00D, "R3 dword");
        expect_val(4'd1, 64'h0000_0000_CAFE_F00D, "R3 dword clears upper");
        do_write(4'd2, 2'd3, 2'd0, 3'd0, 64'hDEAD_BEEF_0123_4567, "R3 qword");
        expect_val(4'd2, 64'hDEAD_BEEF_0123_4567, "R3 qword full");

        // R4: zero extension
        do_write(4'd3, 2'd3, 2'd0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R7 preset r3");
        do_write(4'd3, 2'd1, 2'd0, 3'd1, 64'h0000_0000_0000_0080, "R4 zext b->w");
        expect_val(4'd3, 64'hFFFF_FFFF_FFFF_0080, "R4 zext b->w merge");
        do_write(4'd3, 2'd3, 2'd0, 3'd1, 64'h5555_5555_5555_55AA, "R4 zext b->q");
        expect_val(4'd3, 64'h0000_0000_0000_00AA, "R4 zext b->q");
        do_write(4'd3, 2'd2, 2'd1, 3'd1, 64'hFFFF_FFFF_FFFF_9876, "R4 zext w->d");
        expect_val(4'd3, 64'h0000_0000_0000_9876, "R4 zext w->d");
        do_write(4'd3, 2'd3, 2'd1, 3'd1, 64'hFFFF_FFFF_FFFF_8001, "R4 zext w->q");
        expect_val(4'd3, 64'h0000_0000_0000_8001, "R4 zext w->q");

        // R5: sign extension
        do_write(4'd4, 2'd3, 2'd0, 3'd2, 64'h0000_0000_0000_00AA, "R5 sext b->q");
        expect_val(4'd4, 64'hFFFF_FFFF_FFFF_FFAA, "R5 sext b->q");
        do_write(4'd5, 2'd3, 2'd0, 3'd4, 64'h0011_2233_4455_6677, "R7 preset r5");
        do_write(4'd5, 2'd1, 2'd0, 3'd2, 64'h0000_0000_0000_0080, "R5 sext b->w");
        expect_val(4'd5, 64'h0011_2233_4455_FF80, "R5 sext b->w merge");
        do_write(4'd6, 2'd3, 2'd2, 3'd2, 64'h0000_0000_8000_0000, "R5 sext d->q");
        expect_val(4'd6, 64'hFFFF_FFFF_8000_0000, "R5 sext d->q");
        do_write(4'd6, 2'd2, 2'd1, 3'd2, 64'hFFFF_FFFF_FFFF_7FFF, "R5 sext w->d positive");
        expect_val(4'd6, 64'h0000_0000_0000_7FFF, "R5 sext w->d positive");

        // R6: illegal combinations change nothing
        do_write(4'd2, 2'd3, 2'd2, 3'd1, 64'h0, "R6 zext d->q illegal");
        expect_val(4'd2, 64'hDEAD_BEEF_0123_4567, "R6 zext d->q unchanged");
        do_write(4'd2, 2'd0, 2'd1, 3'd2, 64'h0, "R6 sext src>dst illegal");
        do_write(4'd2, 2'd0, 2'd0, 3'd1, 64'h0, "R6 zext equal size illegal");
        do_write(4'd2, 2'd3, 2'd0, 3'd6, 64'h0, "R6 mode6 illegal");
        do_write(4'd2, 2'd3, 2'd0, 3'd7, 64'h0, "R6 mode7 illegal");
        expect_val(4'd2, 64'hDEAD_BEEF_0123_4567, "R6 register unchanged");

        // R7: 32-bit immediate and size rule
        do_write(4'd7, 2'd3, 2'd0, 3'd3, 64'h1234_5678_8000_0001, "R7 imm32 negative");
        expect_val(4'd7, 64'hFFFF_FFFF_8000_0001, "R7 imm32 negative");
        do_write(4'd7, 2'd3, 2'd3, 3'd3, 64'hFFFF_FFFF_7FFF_FFFF, "R7 imm32 positive");
        expect_val(4'd7, 64'h0000_0000_7FFF_FFFF, "R7 imm32 positive");
        do_write(4'd7, 2'd2, 2'd0, 3'd3, 64'h1, "R7 imm32 dword illegal");
        do_write(4'd7, 2'd1, 2'd0, 3'd4, 64'h1, "R7 imm64 word illegal");
        expect_val(4'd7, 64'h0000_0000_7FFF_FFFF, "R7 illegal immediates unchanged");

        // R8: accumulator widen ignores address and data
        do_write(4'd0, 2'd3, 2'd0, 3'd4, 64'h1111_1111_8765_4321, "R7 preset r0");
        do_write(4'd5, 2'd0, 2'd0, 3'd5, 64'h0, "R8 accumulator widen negative");
        expect_val(4'd0, 64'hFFFF_FFFF_8765_4321, "R8 r0 widened");
        expect_val(4'd5, 64'h0011_2233_4455_FF80, "R8 named register untouched");
        do_write(4'd0, 2'd3, 2'd0, 3'd4, 64'hFFFF_FFFF_1234_5678, "R7 preset r0 again");
        do_write(4'd9, 2'd1, 2'd2, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, "R8 accumulator widen positive");
        expect_val(4'd0, 64'h0000_0000_1234_5678, "R8 r0 widened positive");

        // R9: read sizes on both ports
        check_b(4'd2, 2'd0, "R9 port B byte");
        check_b(4'd2, 2'd1, "R9 port B word");
        check_b(4'd2, 2'd2, "R9 port B dword");
        check_a(4'd4, 2'd1, "R9 port A word");
        check_a(4'd2, 2'd0, "R9 port A byte");

        // R1: no write enable means no change and no error
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'd2; wr_size = 2'd3; wr_mode = 3'd7;
        wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
        push(2, 64'h0, "R1 no error without enable");
        expect_val(4'd2, 64'hDEAD_BEEF_0123_4567, "R1 no write without enable");
        wr_mode = 3'd0;

        // R10: reset in mid-run
        do_reset();
        for (int k = 0; k < 8; k++) check_a(4'(k), 2'd3, "R10 mid-run reset clears");

        @(negedge clk);
        #5;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule